// File: doc/BRIEF.md
# Boundary Scan Register with Bypass Bit

This block places one scan cell on every functional input pin and every functional output pin of a core. Each cell has two flip-flops. A capture stage sits in a serial chain that runs from `ser_in` to `ser_out`. A separate update stage holds a value that can be applied in place of the functional signal. Shifting moves bits only through the capture stages. The applied values change only when `update_en` copies the whole capture chain into the update stages in one cycle.

A 2-bit operation code selects the behaviour. There are three modes:
- **Transparent sampling**: pins and core pass through unchanged, while snapshots are captured and shifted out, or new values are preloaded.
- **External test**: the update stages drive the output pins and the core inputs.
- **Bypass**: the serial path is cut down to a single flip-flop.

The capture, shift and update strobes come from a separate port controller. They are plain level-sensitive enables, sampled on the rising edge of `clk`.

Top module: `edge_scan_register`

## Requirements
- R1: While `rst_n` is low, every capture bit, update bit and the bypass bit is cleared to 0. After release with no strobe, `ser_out` reads 0.
- R2: The operation codes are 2'b00 external test, 2'b01 sampling, and 2'b10 or 2'b11 bypass. Under 2'b00 or 2'b01, `shift_en` moves every capture bit one cell toward `ser_out`. `ser_in` enters cell TOTAL-1, and `ser_out` shows cell 0. A bit shifted in appears at `ser_out` after TOTAL shifts.
- R3: Under 2'b00 or 2'b01, `capture_en` without `shift_en` loads cells 0..N_IN-1 from `pin_in[0..N_IN-1]`, and cells N_IN..TOTAL-1 from `core_out[0..N_OUT-1]`.
- R4: When `capture_en` and `shift_en` are both high, the chain shifts and does not capture.
- R5: The update stages change only on a cycle with `update_en` high under 2'b00 or 2'b01. On that cycle they all load the pre-edge capture bits. Shifting alone never changes `pin_out` or `core_in`.
- R6: Under 2'b01, 2'b10 and 2'b11, `pin_out` equals `core_out` and `core_in` equals `pin_in` in the same cycle, whatever the update stages hold.
- R7: Under 2'b00, `pin_out[j]` equals update bit N_IN+j and `core_in[i]` equals update bit i, independent of `core_out` and `pin_in`.
- R8: Under a bypass code, `ser_out` shows the bypass bit. A shift loads it from `ser_in`, so a bit emerges after one shift. A capture without shift loads it with 0.
- R9: Under a bypass code, the capture, shift and update strobes leave every capture bit and update bit unchanged.
- R10: Under 2'b00 or 2'b01, the bypass bit holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 2 | Operation: 00 external test, 01 sampling, 10/11 bypass |
| capture_en | input | 1 | Load functional values into the selected register |
| shift_en | input | 1 | Shift the selected register one place; wins over capture |
| update_en | input | 1 | Copy capture chain into update stages |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Serial data out, from cell 0 or the bypass bit |
| pin_in | input | N_IN | Values arriving at the device input pins |
| core_in | output | N_IN | Values delivered to the core inputs |
| core_out | input | N_OUT | Values produced by the core for the output pins |
| pin_out | output | N_OUT | Values driven on the device output pins |

## Verification
The embedded properties assume that the operation code is held steady across any cycle in which a strobe is high. They also assume that every strobe is settled before the rising edge. The stimulus therefore changes the code only in a cycle where all strobes are low, and drives every input on the falling edge. The properties do not require capture and shift to be exclusive. The stimulus raises both together once, on purpose, so that the priority rule is exercised. A reference model in the bench tracks the chain, the update stages and the bypass bit from the requirements. A scoreboard queue then compares every bit that leaves `ser_out`.

// File: rtl/esr_pkg.sv
package esr_pkg;

  typedef enum logic [1:0] {
    OP_EXT_TEST = 2'b00,
    OP_SAMPLING = 2'b01,
    OP_RESERVED = 2'b10,
    OP_BYPASS   = 2'b11
  } op_e;

  typedef struct packed {
    logic chain_sel;  // boundary chain owns the serial path
    logic byp_sel;    // single bypass bit owns the serial path
    logic drive_upd;  // update stages drive pins and core
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic [1:0] code);
    op_dec_t d;
    d.chain_sel = (code == OP_EXT_TEST) || (code == OP_SAMPLING);
    d.byp_sel   = !d.chain_sel;
    d.drive_upd = (code == OP_EXT_TEST);
    return d;
  endfunction

endpackage

// File: rtl/esr_cell.sv
module esr_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic drive_upd,
  input  logic capture_en,
  input  logic shift_en,
  input  logic update_en,
  input  logic scan_prev,
  input  logic func_in,
  output logic cap_q,
  output logic func_out
);

  logic upd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= 1'b0;
    end else if (sel) begin
      if (shift_en)        cap_q <= scan_prev;
      else if (capture_en) cap_q <= func_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                upd_q <= 1'b0;
    else if (sel && update_en) upd_q <= cap_q;
  end

  always_comb func_out = drive_upd ? upd_q : func_in;

  AST_SHIFT_FROM_NEIGHBOUR: assert property (@(posedge clk) disable iff (!rst_n)
    sel && shift_en |=> cap_q == $past(scan_prev)); // R2
  AST_CAPTURE_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
    sel && capture_en && !shift_en |=> cap_q == $past(func_in)); // R3
  AST_SHIFT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sel && capture_en && shift_en |=> cap_q == $past(scan_prev)); // R4
  AST_UPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && update_en) |=> $stable(upd_q)); // R5
  AST_CHAIN_IDLE_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(cap_q)); // R9

endmodule

// File: rtl/esr_bypass.sv
module esr_bypass (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic capture_en,
  input  logic shift_en,
  input  logic ser_in,
  output logic byp_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
    end else if (sel) begin
      if (shift_en)        byp_q <= ser_in;
      else if (capture_en) byp_q <= 1'b0;
    end
  end

  AST_BYP_CAPTURE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sel && capture_en && !shift_en |=> !byp_q); // R8
  AST_BYP_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    sel && shift_en |=> byp_q == $past(ser_in)); // R8
  AST_BYP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(byp_q)); // R10

endmodule

// File: rtl/edge_scan_register.sv
module edge_scan_register #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op_code,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic             ser_in,
  output logic             ser_out,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pin_out
);
  import esr_pkg::*;

  localparam int TOTAL = N_IN + N_OUT;

  op_dec_t          dec;
  logic [TOTAL:0]   link;
  logic [TOTAL-1:0] func_src;
  logic [TOTAL-1:0] func_dst;
  logic             byp_q;

  always_comb dec = decode_op(op_code);

  assign func_src    = {core_out, pin_in};
  assign link[TOTAL] = ser_in;

  for (genvar g = 0; g < TOTAL; g++) begin : g_cell
    esr_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (dec.chain_sel),
      .drive_upd  (dec.drive_upd),
      .capture_en (capture_en),
      .shift_en   (shift_en),
      .update_en  (update_en),
      .scan_prev  (link[g+1]),
      .func_in    (func_src[g]),
      .cap_q      (link[g]),
      .func_out   (func_dst[g])
    );
  end

  esr_bypass u_bypass (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (dec.byp_sel),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .ser_in     (ser_in),
    .byp_q      (byp_q)
  );

  assign core_in = func_dst[N_IN-1:0];
  assign pin_out = func_dst[TOTAL-1:N_IN];
  assign ser_out = dec.byp_sel ? byp_q : link[0];

  AST_PINS_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    op_code != 2'b00 |-> pin_out == core_out && core_in == pin_in); // R6
  AST_EXTEST_IGNORES_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    op_code == 2'b00 && $past(op_code) == 2'b00 && !$past(update_en)
    |-> $stable(pin_out)); // R7
  AST_BYPASS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    op_code[1] && $past(op_code[1]) && $past(shift_en) |-> ser_out == $past(ser_in)); // R8

endmodule

// File: tb/test_edge_scan_register.sv
`timescale 1ns/1ps
module test_edge_scan_register;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int NT = NI + NO;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic          rst_n, capture_en, shift_en, update_en, ser_in, ser_out;
  logic [1:0]    op_code;
  logic [NI-1:0] pin_in, core_in;
  logic [NO-1:0] core_out, pin_out;

  edge_scan_register #(.N_IN(NI), .N_OUT(NO)) i_edge_scan_register (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .ser_in(ser_in), .ser_out(ser_out),
    .pin_in(pin_in), .core_in(core_in), .core_out(core_out), .pin_out(pin_out)
  );

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit exp_q[$];
  string req_q[$];
  logic [NT-1:0] m_cap, m_upd;
  logic m_byp;

  function automatic bit is_chain(input logic [1:0] op);
    return op == 2'b00 || op == 2'b01;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard for each bit about to leave ser_out
  initial forever begin
    @(negedge clk);
    #5;
    if (mon_on && shift_en) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard underflow actual %0h expected none", ser_out);
      end else begin
        bit e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(r, 32'(ser_out), 32'(e));
      end
    end
  end

  // driver: one clock of strobes; updates the reference model
  task automatic cycle(input logic cap, input logic sh, input logic upd,
                       input logic si, input string req);
    logic [NT-1:0] old_cap;
    @(negedge clk);
    capture_en = cap; shift_en = sh; update_en = upd; ser_in = si;
    old_cap = m_cap;
    if (is_chain(op_code)) begin
      if (sh) begin
        exp_q.push_back(m_cap[0]); req_q.push_back(req);
        m_cap = {si, m_cap[NT-1:1]};
      end else if (cap) begin
        m_cap = {core_out, pin_in};
      end
      if (upd) m_upd = old_cap;
    end else begin
      if (sh) begin
        exp_q.push_back(m_byp); req_q.push_back(req);
        m_byp = si;
      end else if (cap) begin
        m_byp = 1'b0;
      end
    end
  endtask

  task automatic shift_word(input logic [NT-1:0] w, input string req);
    for (int i = 0; i < NT; i++) cycle(1'b0, 1'b1, 1'b0, w[i], req);
  endtask

  task automatic settle();
    @(negedge clk);
    capture_en = 0; shift_en = 0; update_en = 0; ser_in = 0;
    #5;
  endtask

  task automatic set_op(input logic [1:0] v);
    @(negedge clk);
    capture_en = 0; shift_en = 0; update_en = 0;
    op_code = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; op_code = 2'b01; capture_en = 0; shift_en = 0; update_en = 0;
    ser_in = 0; pin_in = '0; core_out = '0;
    m_cap = '0; m_upd = '0; m_byp = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset state
    settle();
    check("R1 ser_out", 32'(ser_out), 32'd0);
    set_op(2'b00); settle();
    check("R1 update cleared pin_out", 32'(pin_out), 32'd0);
    check("R1 update cleared core_in", 32'(core_in), 32'd0);
    set_op(2'b11); settle();
    check("R1 bypass cleared", 32'(ser_out), 32'd0);
    set_op(2'b01);
    mon_on = 1'b1;

    // R3 capture then R2 shift through
    pin_in = 4'hA; core_out = 4'h5;
    cycle(1, 0, 0, 0, "R3");
    shift_word(8'hC3, "R3");
    shift_word(8'h00, "R2");

    // R4: capture and shift together -> shift
    pin_in = 4'hF; core_out = 4'hF;
    cycle(1, 1, 0, 1, "R4");
    shift_word(8'h00, "R4");

    // R6: sampling keeps pins transparent after update
    shift_word(8'h96, "R2");
    cycle(0, 0, 1, 0, "R5");
    settle();
    check("R6 pin_out", 32'(pin_out), 32'(core_out));
    check("R6 core_in", 32'(core_in), 32'(pin_in));

    // R7: external test applies update stages
    set_op(2'b00); settle();
    check("R7 pin_out", 32'(pin_out), 32'(m_upd[NT-1:NI]));
    check("R7 core_in", 32'(core_in), 32'(m_upd[NI-1:0]));
    core_out = 4'h0; pin_in = 4'h0; settle();
    check("R7 pin_out ignores core_out", 32'(pin_out), 32'h9);
    check("R7 core_in ignores pin_in", 32'(core_in), 32'h6);

    // R5: shift without update leaves pins, update copies
    shift_word(8'h3C, "R2");
    settle();
    check("R5 pin_out held during shift", 32'(pin_out), 32'h9);
    cycle(0, 0, 1, 0, "R5");
    settle();
    check("R5 pin_out after update", 32'(pin_out), 32'h3);
    check("R5 core_in after update", 32'(core_in), 32'hC);

    // R8: bypass path
    set_op(2'b11);
    cycle(0, 1, 0, 1, "R8");
    cycle(1, 0, 0, 0, "R8");
    settle();
    check("R8 capture zero", 32'(ser_out), 32'd0);
    cycle(0, 1, 0, 1, "R8");
    cycle(0, 1, 0, 0, "R8");
    cycle(0, 1, 0, 1, "R8");
    settle();
    check("R8 one-bit delay", 32'(ser_out), 32'd1);
    check("R6 bypass transparent", 32'(pin_out), 32'(core_out));

    // R9: strobes under bypass leave chain and update stages alone
    pin_in = 4'h5; core_out = 4'hA;
    cycle(1, 0, 1, 0, "R9");
    shift_word(8'hA5, "R8");
    cycle(0, 1, 0, 1, "R8");
    set_op(2'b00); settle();
    check("R9 update unchanged pin_out", 32'(pin_out), 32'h3);
    check("R9 update unchanged core_in", 32'(core_in), 32'hC);

    // R10: bypass bit holds under chain codes
    set_op(2'b01);
    shift_word(8'h00, "R9");
    cycle(1, 0, 1, 0, "R10");
    set_op(2'b10); settle();
    check("R10 bypass held", 32'(ser_out), 32'd1);
    cycle(0, 1, 0, 0, "R10");
    settle();

    mon_on = 1'b0;
    check("scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule